// File: doc/BRIEF.md
# Result Snapshot Change Scanner with Nonce Decode

This block watches the result area of a hashing engine. The area is read back as a snapshot of sixteen 32-bit result slots plus one 32-bit job-marker word. The block keeps the last snapshot it accepted. When a new snapshot carries a job marker different from the stored one, the block flags a job switch. It then reports every result slot whose value differs from the stored copy.

Each reported slot value passes through a fixed decoding step that turns the raw slot bits into a nonce. That nonce then yields three candidate nonces, each at a fixed offset. The candidates go out on a valid/ready stream, and a downstream checker tests them against the work item.

The snapshot port is also valid/ready. While candidates are still pending, the block holds `snap_ready` low. A producer can therefore leave a snapshot on the port until the scan of the previous one has drained. On the candidate stream the consumer may hold `cand_ready` low for any number of cycles. While it does, the offered candidate stays fixed.

Top module: `nonce_change_scan`

## Requirements
- R1: After reset, `snap_ready` is 1, `cand_valid` is 0 and `job_switch` is 0.
- R2: The first snapshot accepted after reset is stored only. It produces no candidate and no `job_switch` pulse.
- R3: A snapshot accepted while a copy is stored, whose marker word differs from the stored marker, is a job switch. `job_switch` is 1 for exactly the one cycle after the accepting clock edge.
- R4: A snapshot with the same marker as the stored one produces no candidate and no pulse. The stored copy keeps its old slot values, and later comparisons are made against those old values.
- R5: On a job switch, each slot whose new value differs from its stored value produces candidates, and `cand_slot` carries that slot's index. Slots are served in ascending index order, and unchanged slots produce nothing.
- R6: The decode of a raw slot word x is assembled as follows, before the subtraction of R7. Bits [31:24] take x[7:0]. Let t be x[31:8] with each of its three bytes bit-reversed in place. Bits [21:0] take t[23:2], bit 23 takes t[0] and bit 22 takes t[1].
- R7: The decoded value is the R6 assembly minus 0x00800004, modulo 2^32. For example, raw 0x0000C000 decodes to 0x003FFFFC.
- R8: Each changed slot gives three consecutive candidates. With decoded value d, `cand_kind` 0 carries d−0x00800000, kind 1 carries d, and kind 2 carries d−0x00400000, all modulo 2^32.
- R9: A candidate is taken on a cycle where `cand_valid` and `cand_ready` are both 1. While it is not taken, `cand_nonce`, `cand_slot` and `cand_kind` hold steady. `snap_ready` is 0 while any candidate is pending.
- R10: On a job switch the whole stored snapshot is replaced by the new one. A switch in which no slot differs pulses `job_switch` and emits no candidate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snap_valid | input | 1 | Snapshot offered |
| snap_ready | output | 1 | Block can accept a snapshot (no candidates pending) |
| snap_words | input | 512 | Result slots; slot i at bits [32*i+31:32*i] |
| snap_marker | input | 32 | Job-marker word of the snapshot |
| cand_valid | output | 1 | Candidate offered |
| cand_ready | input | 1 | Consumer takes the candidate |
| cand_nonce | output | 32 | Candidate nonce |
| cand_slot | output | 4 | Index of the slot the candidate came from |
| cand_kind | output | 2 | Offset variant: 0, 1 or 2 as in R8 |
| job_switch | output | 1 | One-cycle pulse after a job switch is accepted |

## Verification
The assertions check the stream rules on every cycle: a stalled candidate holds steady and no snapshot is taken while candidates are pending. They also check that a slot keeps its index through its three kinds and that slot indices only rise within a scan. The spacing between kinds is checked as well (kind 1 equals kind 0 plus 0x800000, and kind 2 equals kind 1 minus 0x400000), together with the rule that a same-marker snapshot leaves the stored copy alone. Only the bench scenarios can show the rest. These are the absolute decoded values against a bit-level model and a known literal, which slots a given pair of snapshots selects, the priming of the first snapshot, and the fact that a replaced copy really changes the outcome of later comparisons.

// File: rtl/nsc_pkg.sv
package nsc_pkg;
  localparam int unsigned NSC_WORD_W  = 32;
  localparam int unsigned NSC_KINDS   = 3;
  localparam int unsigned NSC_KIND_W  = 2;

  typedef logic [NSC_WORD_W-1:0] word_t;
  typedef logic [NSC_KIND_W-1:0] kind_t;

  localparam word_t NSC_DEC_BIAS = 32'h0080_0004;
  localparam kind_t NSC_LAST_KIND = kind_t'(NSC_KINDS - 1);

  // offset subtracted from the decoded value for each candidate kind
  function automatic word_t nsc_kind_offset(input kind_t k);
    case (k)
      2'd0:    return 32'h0080_0000;
      2'd1:    return 32'h0000_0000;
      default: return 32'h0040_0000;
    endcase
  endfunction
endpackage

// File: rtl/nsc_nonce_decode.sv
module nsc_nonce_decode
  import nsc_pkg::*;
(
  input  word_t raw,
  output word_t decoded
);
  localparam int unsigned HI_BYTES = (NSC_WORD_W / 8) - 1;

  logic [HI_BYTES*8-1:0] upper;
  logic [HI_BYTES*8-1:0] flipped;
  word_t                 assembled;

  assign upper = raw[NSC_WORD_W-1:8];

  for (genvar g = 0; g < HI_BYTES; g++) begin : g_byte
    for (genvar b = 0; b < 8; b++) begin : g_bit
      assign flipped[g*8+b] = upper[g*8+7-b];
    end
  end

  // low byte to the top, two low flipped bits swapped into 23/22
  assign assembled = {raw[7:0], flipped[0], flipped[1], flipped[HI_BYTES*8-1:2]};
  assign decoded   = assembled - NSC_DEC_BIAS;
endmodule

// File: rtl/nsc_snap_store.sv
module nsc_snap_store
  import nsc_pkg::*;
#(
  parameter int unsigned SLOTS = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [SLOTS*NSC_WORD_W-1:0] new_words,
  input  word_t                      new_marker,
  output logic                       switch_now,
  output logic [SLOTS-1:0]           diff_mask,
  output logic [SLOTS*NSC_WORD_W-1:0] held_words,
  output logic                       job_switch_q
);
  logic                        primed_q;
  word_t                       marker_q;
  logic [SLOTS*NSC_WORD_W-1:0] words_q;

  assign switch_now = primed_q && (new_marker != marker_q);
  assign held_words = words_q;

  for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
    assign diff_mask[i] =
      new_words[i*NSC_WORD_W +: NSC_WORD_W] != words_q[i*NSC_WORD_W +: NSC_WORD_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed_q     <= 1'b0;
      marker_q     <= '0;
      words_q      <= '0;
      job_switch_q <= 1'b0;
    end else begin
      job_switch_q <= load && switch_now;
      if (load && (!primed_q || switch_now)) begin
        primed_q <= 1'b1;
        marker_q <= new_marker;
        words_q  <= new_words;
      end
    end
  end

  // R2: priming load raises no switch flag
  a_r2_prime_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !primed_q) |=> (primed_q && !job_switch_q));

  // R4: same-marker snapshot leaves the stored copy intact
  a_r4_keep_same_job: assert property (@(posedge clk) disable iff (!rst_n)
    (load && primed_q && !switch_now) |=> ($stable(marker_q) && $stable(words_q)));
endmodule

// File: rtl/nsc_slot_walker.sv
module nsc_slot_walker
  import nsc_pkg::*;
#(
  parameter int unsigned SLOTS = 16,
  localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SLOTS-1:0]  start_mask,
  input  logic              take,
  output logic              busy,
  output logic [SLOT_W-1:0] slot_idx,
  output kind_t             kind
);
  logic [SLOTS-1:0] pend_q;
  kind_t            kind_q;
  logic             fire;

  assign busy = |pend_q;
  assign kind = kind_q;
  assign fire = busy && take;

  // lowest pending index wins
  always_comb begin
    slot_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (pend_q[i]) slot_idx = SLOT_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      kind_q <= '0;
    end else if (start) begin
      pend_q <= start_mask;
      kind_q <= '0;
    end else if (fire) begin
      if (kind_q == NSC_LAST_KIND) begin
        kind_q           <= '0;
        pend_q[slot_idx] <= 1'b0;
      end else begin
        kind_q <= kind_q + 1'b1;
      end
    end
  end

  // R9: a new scan only starts once the previous one drained
  a_r9_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  // R5: a slot keeps its index through all its kinds
  a_r5_slot_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && kind_q != NSC_LAST_KIND) |=> (busy && slot_idx == $past(slot_idx)));

  // R5: slots are served in ascending order
  a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && kind_q == NSC_LAST_KIND) |=> (!busy || slot_idx > $past(slot_idx)));

  // R8: kind never leaves its range
  a_r8_kind_range: assert property (@(posedge clk) disable iff (!rst_n)
    kind_q <= NSC_LAST_KIND);
endmodule

// File: rtl/nonce_change_scan.sv
module nonce_change_scan
  import nsc_pkg::*;
#(
  parameter int unsigned SLOTS = 16,
  localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        snap_valid,
  output logic                        snap_ready,
  input  logic [SLOTS*NSC_WORD_W-1:0] snap_words,
  input  logic [NSC_WORD_W-1:0]       snap_marker,
  output logic                        cand_valid,
  input  logic                        cand_ready,
  output logic [NSC_WORD_W-1:0]       cand_nonce,
  output logic [SLOT_W-1:0]           cand_slot,
  output logic [NSC_KIND_W-1:0]       cand_kind,
  output logic                        job_switch
);
  logic                        load;
  logic                        switch_now;
  logic [SLOTS-1:0]            diff_mask;
  logic [SLOTS*NSC_WORD_W-1:0] held_words;
  logic                        busy;
  logic [SLOT_W-1:0]           slot_idx;
  kind_t                       kind;
  word_t                       raw_sel;
  word_t                       decoded;

  assign snap_ready = !busy;
  assign load       = snap_valid && snap_ready;

  nsc_snap_store #(.SLOTS(SLOTS)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (load),
    .new_words    (snap_words),
    .new_marker   (snap_marker),
    .switch_now   (switch_now),
    .diff_mask    (diff_mask),
    .held_words   (held_words),
    .job_switch_q (job_switch)
  );

  nsc_slot_walker #(.SLOTS(SLOTS)) u_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (load && switch_now),
    .start_mask (diff_mask),
    .take       (cand_ready),
    .busy       (busy),
    .slot_idx   (slot_idx),
    .kind       (kind)
  );

  assign raw_sel = held_words[slot_idx*NSC_WORD_W +: NSC_WORD_W];

  nsc_nonce_decode u_decode (
    .raw     (raw_sel),
    .decoded (decoded)
  );

  assign cand_valid = busy;
  assign cand_slot  = slot_idx;
  assign cand_kind  = kind;
  assign cand_nonce = decoded - nsc_kind_offset(kind);

  // R9: stalled candidate holds steady
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && !cand_ready) |=>
      (cand_valid && $stable(cand_nonce) && $stable(cand_slot) && $stable(cand_kind)));

  // R9: no snapshot taken while candidates pend
  a_r9_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> !snap_ready);

  // R8: kind 1 sits 0x800000 above kind 0
  a_r8_step_first: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && cand_ready && cand_kind == 2'd0) |=>
      (cand_valid && cand_kind == 2'd1 && cand_nonce == $past(cand_nonce) + 32'h0080_0000));

  // R8: kind 2 sits 0x400000 below kind 1
  a_r8_step_second: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && cand_ready && cand_kind == 2'd1) |=>
      (cand_valid && cand_kind == 2'd2 && cand_nonce == $past(cand_nonce) - 32'h0040_0000));
endmodule

// File: tb/test_nonce_change_scan.sv
`timescale 1ns/1ps
module test_nonce_change_scan;
  localparam int NS = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          snap_valid = 1'b0;
  logic          snap_ready;
  logic [NS*32-1:0] snap_words = '0;
  logic [31:0]   snap_marker = '0;
  logic          cand_valid;
  logic          cand_ready = 1'b0;
  logic [31:0]   cand_nonce;
  logic [3:0]    cand_slot;
  logic [1:0]    cand_kind;
  logic          job_switch;

  int n_cmp = 0;
  int n_bad = 0;

  // bench model state
  logic [31:0] m_slots [NS];
  logic [31:0] m_marker;
  bit          m_primed;
  logic [31:0] cur_w [NS];
  logic [31:0] exp_n [48];
  int          exp_s [48];
  int          exp_k [48];
  int          exp_cnt;
  logic [31:0] got_n [48];

  always #5 clk = ~clk;

  nonce_change_scan i_nonce_change_scan (
    .clk(clk), .rst_n(rst_n),
    .snap_valid(snap_valid), .snap_ready(snap_ready),
    .snap_words(snap_words), .snap_marker(snap_marker),
    .cand_valid(cand_valid), .cand_ready(cand_ready),
    .cand_nonce(cand_nonce), .cand_slot(cand_slot), .cand_kind(cand_kind),
    .job_switch(job_switch)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] ref_decode(input logic [31:0] x);
    logic [23:0] y, t;
    logic [31:0] o;
    y = x[31:8];
    for (int k = 0; k < 24; k++) t[k] = y[(k/8)*8 + 7 - (k%8)];
    o = '0;
    o[31:24] = x[7:0];
    for (int k = 0; k < 22; k++) o[k] = t[k+2];
    o[23] = t[0];
    o[22] = t[1];
    return o - 32'h0080_0004;
  endfunction

  // model update and expected candidate list
  task automatic model_step(input logic [31:0] marker, output bit sw);
    logic [31:0] d;
    exp_cnt = 0;
    sw = 1'b0;
    if (!m_primed) begin
      m_primed = 1'b1;
      m_marker = marker;
      for (int i = 0; i < NS; i++) m_slots[i] = cur_w[i];
    end else if (marker != m_marker) begin
      sw = 1'b1;
      for (int i = 0; i < NS; i++) begin
        if (cur_w[i] != m_slots[i]) begin
          d = ref_decode(cur_w[i]);
          exp_n[exp_cnt] = d - 32'h0080_0000; exp_s[exp_cnt] = i; exp_k[exp_cnt] = 0; exp_cnt++;
          exp_n[exp_cnt] = d;                 exp_s[exp_cnt] = i; exp_k[exp_cnt] = 1; exp_cnt++;
          exp_n[exp_cnt] = d - 32'h0040_0000; exp_s[exp_cnt] = i; exp_k[exp_cnt] = 2; exp_cnt++;
        end
        m_slots[i] = cur_w[i];
      end
      m_marker = marker;
    end
  endtask

  // offer cur_w with marker, then drain; stall_mode 1 inserts back-pressure
  task automatic send_and_drain(input logic [31:0] marker, input int stall_mode, input string req);
    bit sw;
    int idx = 0;
    bit held = 1'b0;
    logic [31:0] h_n;
    logic [3:0]  h_s;
    logic [1:0]  h_k;
    model_step(marker, sw);
    @(negedge clk);
    check(snap_ready == 1'b1, "R9", 32'(snap_ready), 32'd1);
    for (int i = 0; i < NS; i++) snap_words[i*32 +: 32] = cur_w[i];
    snap_marker = marker;
    snap_valid  = 1'b1;
    @(negedge clk);
    snap_valid = 1'b0;
    check(job_switch == sw, sw ? "R3" : req, 32'(job_switch), 32'(sw));
    for (int cyc = 0; cyc < 400; cyc++) begin
      if (held) begin
        check(cand_valid && cand_nonce == h_n && cand_slot == h_s && cand_kind == h_k,
              "R9", cand_nonce, h_n);
        held = 1'b0;
      end
      if (!cand_valid) break;
      cand_ready = (stall_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
      if (cand_ready) begin
        if (idx < exp_cnt) begin
          check(cand_nonce == exp_n[idx], "R8", cand_nonce, exp_n[idx]);
          check(32'(cand_slot) == 32'(exp_s[idx]), "R5", 32'(cand_slot), 32'(exp_s[idx]));
          check(32'(cand_kind) == 32'(exp_k[idx]), "R8", 32'(cand_kind), 32'(exp_k[idx]));
          got_n[idx] = cand_nonce;
        end
        idx++;
      end else begin
        held = 1'b1;
        h_n = cand_nonce; h_s = cand_slot; h_k = cand_kind;
      end
      @(negedge clk);
      if (cyc == 0) check(job_switch == 1'b0, "R3", 32'(job_switch), 32'd0);
    end
    cand_ready = 1'b0;
    check(idx == exp_cnt, req, 32'(idx), 32'(exp_cnt));
    check(snap_ready == 1'b1, "R9", 32'(snap_ready), 32'd1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(snap_ready == 1'b1, "R1", 32'(snap_ready), 32'd1);
    check(cand_valid == 1'b0, "R1", 32'(cand_valid), 32'd0);
    check(job_switch == 1'b0, "R1", 32'(job_switch), 32'd0);
    rst_n = 1'b1;
    m_primed = 1'b0;
  endtask

  task automatic t_prime();
    for (int i = 0; i < NS; i++) cur_w[i] = 32'h1111_1111 * (i + 1);
    send_and_drain(32'h0000_0010, 0, "R2");
  endtask

  task automatic t_same_job();
    cur_w[2] = 32'hDEAD_0002;
    cur_w[5] = 32'hBEEF_0005;
    send_and_drain(32'h0000_0010, 0, "R4");
  endtask

  task automatic t_switch_stalled();
    // slots 2 and 5 revert to primed values: nothing from them (R4)
    for (int i = 0; i < NS; i++) cur_w[i] = 32'h1111_1111 * (i + 1);
    cur_w[1]  = 32'h0A0B_0C0D;
    cur_w[7]  = 32'hFFFF_FFFF;
    cur_w[15] = 32'h1234_5678;
    send_and_drain(32'h0000_0011, 1, "R5");
  endtask

  task automatic t_decode_literal();
    cur_w[3] = 32'h0000_C000;
    send_and_drain(32'h0000_0012, 0, "R6");
    check(got_n[0] == 32'hFFBF_FFFC, "R6", got_n[0], 32'hFFBF_FFFC);
    check(got_n[1] == 32'h003F_FFFC, "R7", got_n[1], 32'h003F_FFFC);
    check(got_n[2] == 32'hFFFF_FFFC, "R8", got_n[2], 32'hFFFF_FFFC);
  endtask

  task automatic t_marker_only();
    send_and_drain(32'h0000_0013, 0, "R10");
  endtask

  task automatic t_all_slots();
    for (int i = 0; i < NS; i++) cur_w[i] = 32'h8000_0000 ^ (32'h0101_0101 * i) ^ 32'h0000_00FF;
    send_and_drain(32'hA5A5_0000, 1, "R5");
  endtask

  task automatic t_replaced();
    // new copy stored: a later switch compares against it
    cur_w[9] = 32'h0000_0300;
    send_and_drain(32'hA5A5_0001, 0, "R10");
    check(exp_cnt == 3, "R10", 32'(exp_cnt), 32'd3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_prime();
    t_same_job();
    t_switch_stalled();
    t_decode_literal();
    t_marker_only();
    t_all_slots();
    t_replaced();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule